// File: doc/BRIEF.md
# SPI Serial Flash Read Responder

This block is the target side of a serial NOR flash as seen over a single-bit SPI bus in mode 0 (clock idles low, input sampled on the rising edge, output changed on the falling edge). Once chip select goes low, it takes in an instruction byte. It then serves one of two read commands. The first is an array read that takes a 24-bit address and streams bytes from a small on-chip memory, incrementing the address after every byte. The second is an identification read that streams a fixed header followed by parameter-defined extended bytes.

All SPI pins are sampled by the system clock through a short synchronizer. Edges of the serial clock are detected in the system clock domain, so the whole block runs on one clock. A busy input represents an internal erase or program cycle: a read decoded while it is high produces no output. Raising chip select at any point, including in the middle of a data byte, ends the command and returns the block to idle.

Top module: `spi_flash_reader`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the output enable is low and the block is idle.
- R2: The instruction byte 03h followed by a 24-bit address, both sampled on rising serial-clock edges with the most significant bit first, selects an array read. The array holds 2^ADDR_W bytes indexed by the low ADDR_W address bits, and the byte at index i is (37*i + 90) mod 256.
- R3: The first data bit (the MSB of the first byte) is driven on the falling edge that follows the rising edge sampling the last address bit (or the last instruction bit for an identification read). The data then continues MSB first, one bit per falling edge.
- R4: After every byte shifted out of an array read, the address advances by one, and the stream continues for as long as chip select stays low.
- R5: The address FFFFFFh is followed by 000000h, with no gap in the output.
- R6: A rising chip select at any bit position stops the command. The output enable falls within three system clocks, and the next transaction decodes a fresh instruction.
- R7: A read or identification instruction decoded while busy is high produces no output until chip select next rises.
- R8: The instruction 9Eh streams 20h, BBh, 18h, 10h. It then streams the two extended ID bytes (parameter high byte first) and the 14 configuration bytes (parameter most significant byte first). After those it sends 00h forever.
- R9: Any other instruction byte is ignored, and the output stays disabled until chip select rises.
- R10: The output enable is low whenever chip select is high and during the instruction and address phases. It is high only while data is being streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| busy | input | 1 | High while an internal erase or program cycle runs |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | High when spi_miso is driven, low for high impedance |

## Verification
Each pin crosses two synchronizer flops, and the edge detector feeds the registered output. A serial-clock falling edge therefore shows up on spi_miso by the third system clock edge after it, and a rising chip select clears spi_miso_oe with the same three-edge delay. The bench holds each serial-clock level for six system clocks. It reads spi_miso and spi_miso_oe just before it raises the serial clock, which is well after the output is due and before the next change could arrive. Deselect is checked six clocks after chip select rises, and the expected byte stream is queued before each transaction so that the monitor compares bytes in the order they complete.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_IDENT = 8'h9E;

    localparam logic [7:0] ID_MFR  = 8'h20;
    localparam logic [7:0] ID_TYPE = 8'hBB;
    localparam logic [7:0] ID_CAP  = 8'h18;
    localparam logic [7:0] ID_LEN  = 8'h10;

    localparam int ID_FIXED = 4;
    localparam int ID_EXT   = 2;
    localparam int ID_CFG   = 14;
    // index of the first filler byte; the identification index stops here
    localparam int ID_LAST  = ID_FIXED + ID_EXT + ID_CFG;

    localparam int ADDR_BITS = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RD,
        ST_ID,
        ST_SKIP
    } phase_e;

    // serial-bus events seen in the system clock domain
    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic sel;
        logic mosi;
    } spi_evt_t;

    // contents of array byte i
    function automatic logic [7:0] mem_init(input int unsigned i);
        logic [31:0] t;
        t = i * 32'd37 + 32'd90;
        return t[7:0];
    endfunction

    function automatic logic [7:0] id_byte(input logic [4:0] idx,
                                           input logic [15:0] ext,
                                           input logic [111:0] cfg);
        int unsigned k;
        int unsigned sh;
        k = 32'(idx);
        if (k == 0)                 return ID_MFR;
        else if (k == 1)            return ID_TYPE;
        else if (k == 2)            return ID_CAP;
        else if (k == 3)            return ID_LEN;
        else if (k == 4)            return ext[15:8];
        else if (k == 5)            return ext[7:0];
        else if (k < 32'(ID_LAST)) begin
            sh = 8 * (32'(ID_LAST) - 1 - k);
            return cfg[sh +: 8];
        end
        return 8'h00;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync
    import spi_rd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     mosi,
    output spi_evt_t evt
);

    localparam int NPIN = 3;
    // reset levels: sck low, cs_n high, mosi low
    localparam logic [NPIN-1:0] RST_LVL = 3'b010;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] sync;
    logic            sck_q;

    assign raw = {sck, cs_n, mosi};

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_pin
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_LVL[g]}};
                else     chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign sync[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sync[2];
    end

    always_comb begin
        evt.sck_rise = sync[2] & ~sck_q;
        evt.sck_fall = ~sync[2] & sck_q;
        evt.sel      = ~sync[1];
        evt.mosi     = sync[0];
    end

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_rd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic                 sck_rise,
    input  logic                 mosi,
    input  logic                 busy,
    input  logic                 byte_end,
    output phase_e               phase,
    output logic [ADDR_BITS-1:0] ptr
);

    localparam int CNT_W = $clog2(ADDR_BITS) + 1;
    localparam logic [CNT_W-1:0] OPC_END  = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_BITS - 1);
    localparam logic [ADDR_BITS-1:0] ID_STOP = ADDR_BITS'(ID_LAST);

    logic [6:0]       op_sh;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       op_full;

    assign op_full = {op_sh, mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            cnt   <= '0;
            op_sh <= '0;
            ptr   <= '0;
        end else if (!sel) begin
            phase <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                ST_IDLE: begin
                    phase <= ST_OPC;
                    cnt   <= '0;
                end
                ST_OPC: if (sck_rise) begin
                    op_sh <= op_full[6:0];
                    cnt   <= cnt + 1'b1;
                    if (cnt == OPC_END) begin
                        cnt <= '0;
                        if (busy)                    phase <= ST_SKIP;
                        else if (op_full == OP_READ) phase <= ST_ADDR;
                        else if (op_full == OP_IDENT) begin
                            phase <= ST_ID;
                            ptr   <= '0;
                        end else                     phase <= ST_SKIP;
                    end
                end
                ST_ADDR: if (sck_rise) begin
                    ptr <= {ptr[ADDR_BITS-2:0], mosi};
                    cnt <= cnt + 1'b1;
                    if (cnt == ADDR_END) phase <= ST_RD;
                end
                ST_RD: if (byte_end) begin
                    ptr <= ptr + 1'b1;
                end
                ST_ID: if (byte_end && ptr != ID_STOP) begin
                    ptr <= ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spi_byte_src.sv
module spi_byte_src
    import spi_rd_pkg::*;
#(
    parameter int             ADDR_W   = 6,
    parameter logic [15:0]    EXT_ID   = 16'h0000,
    parameter logic [111:0]   CFG_DATA = 112'h0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 id_mode,
    input  logic [ADDR_BITS-1:0] ptr,
    output logic [7:0]           data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_BITS-1:0] ID_STOP = ADDR_BITS'(ID_LAST);

    logic [7:0] mem [DEPTH];
    logic [4:0] id_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= mem_init(i);
        end
    end

    // clamp so that every index past the table reads the filler byte
    assign id_idx = (ptr > ID_STOP) ? ID_STOP[4:0] : ptr[4:0];

    always_comb begin
        if (id_mode) data = id_byte(id_idx, EXT_ID, CFG_DATA);
        else         data = mem[ptr[ADDR_W-1:0]];
    end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       active,
    input  logic       sck_fall,
    input  logic [7:0] cur_byte,
    output logic       miso,
    output logic       oe,
    output logic       byte_end
);

    logic [6:0] rest;
    logic [2:0] bcnt;

    assign byte_end = sel && active && sck_fall && (bcnt == 3'd7);

    always_ff @(posedge clk) begin
        if (rst || !sel || !active) begin
            oe   <= 1'b0;
            miso <= 1'b0;
            rest <= '0;
            bcnt <= '0;
        end else if (sck_fall) begin
            oe   <= 1'b1;
            bcnt <= bcnt + 1'b1;
            if (bcnt == 3'd0) {miso, rest} <= cur_byte;
            else              {miso, rest} <= {rest, 1'b0};
        end
    end

endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
    import spi_rd_pkg::*;
#(
    parameter int           ADDR_W      = 6,
    parameter int           SYNC_STAGES = 2,
    parameter logic [15:0]  EXT_ID      = 16'h0000,
    parameter logic [111:0] CFG_DATA    = 112'h0
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic busy,
    output logic spi_miso,
    output logic spi_miso_oe
);

    spi_evt_t             evt;
    phase_e               phase;
    logic [ADDR_BITS-1:0] ptr;
    logic [7:0]           cur_byte;
    logic                 byte_end;
    logic                 streaming;

    assign streaming = (phase == ST_RD) || (phase == ST_ID);

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sck  (spi_sck),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi),
        .evt  (evt)
    );

    spi_cmd_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel      (evt.sel),
        .sck_rise (evt.sck_rise),
        .mosi     (evt.mosi),
        .busy     (busy),
        .byte_end (byte_end),
        .phase    (phase),
        .ptr      (ptr)
    );

    spi_byte_src #(
        .ADDR_W   (ADDR_W),
        .EXT_ID   (EXT_ID),
        .CFG_DATA (CFG_DATA)
    ) u_src (
        .clk     (clk),
        .rst     (rst),
        .id_mode (phase == ST_ID),
        .ptr     (ptr),
        .data    (cur_byte)
    );

    spi_tx_shift u_tx (
        .clk      (clk),
        .rst      (rst),
        .sel      (evt.sel),
        .active   (streaming),
        .sck_fall (evt.sck_fall),
        .cur_byte (cur_byte),
        .miso     (spi_miso),
        .oe       (spi_miso_oe),
        .byte_end (byte_end)
    );

endmodule

// File: rtl/spi_flash_reader_chk.sv
module spi_flash_reader_chk
    import spi_rd_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic                 oe,
    input phase_e               phase,
    input logic [ADDR_BITS-1:0] ptr
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (!oe && phase == ST_IDLE)); // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_RD && $past(phase) == ST_RD && ptr != $past(ptr))
        |-> ptr == $past(ptr) + 24'd1); // R4

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !oe); // R6

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_SKIP) |-> !oe); // R7

    AST_ID_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_ID) |-> ptr <= 24'(ID_LAST)); // R8

    AST_OE_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
        oe |-> (phase == ST_RD || phase == ST_ID)); // R10

endmodule

bind spi_flash_reader spi_flash_reader_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (spi_cs_n),
    .oe    (spi_miso_oe),
    .phase (phase),
    .ptr   (ptr)
);

// File: tb/sim_spi_flash_reader.sv
module sim_spi_flash_reader;

    localparam int H = 6;              // system clocks per serial-clock level
    localparam int MAX_CYC = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic busy = 1'b0;
    logic miso;
    logic oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rx_q[$];

    always #10 clk = ~clk;

    spi_flash_reader #(
        .ADDR_W   (6),
        .EXT_ID   (16'hA1B2),
        .CFG_DATA (112'hC0C1C2C3C4C5C6C7C8C9CACBCCCD)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .spi_sck     (sck),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .busy        (busy),
        .spi_miso    (miso),
        .spi_miso_oe (oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R2: array byte i = (37*i + 90) mod 256, i = low 6 address bits
    function automatic logic [7:0] mem_val(input logic [23:0] a);
        logic [31:0] t;
        t = 32'(a[5:0]) * 32'd37 + 32'd90;
        return t[7:0];
    endfunction

    // R8: identification stream for the bench parameters
    function automatic logic [7:0] id_val(input int k);
        logic [31:0] t;
        case (k)
            0: return 8'h20;
            1: return 8'hBB;
            2: return 8'h18;
            3: return 8'h10;
            4: return 8'hA1;
            5: return 8'hB2;
            default: begin
                if (k >= 6 && k < 20) begin
                    t = 32'd192 + 32'(k - 6);
                    return t[7:0];
                end
                return 8'h00;
            end
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic bit_cyc(input logic b, output logic mo, output logic oe_s);
        mosi = b;
        tick(H);
        mo   = miso;
        oe_s = oe;
        sck  = 1'b1;
        tick(H);
        sck  = 1'b0;
    endtask

    // one transaction: opcode, addr_bits of address, data_bits read cycles
    task automatic xfer(input logic [7:0] op, input logic [23:0] addr,
                        input int addr_bits, input int data_bits,
                        input bit expect_out, input string quiet_req);
        logic       mo;
        logic       o;
        logic [7:0] acc;
        acc  = 8'h00;
        cs_n = 1'b0;
        tick(H);
        for (int i = 0; i < 8; i++) begin
            bit_cyc(op[7-i], mo, o);
            check(o == 1'b0, "R10", "oe in instruction phase", int'(o), 0);
        end
        for (int i = 0; i < addr_bits; i++) begin
            bit_cyc(addr[23-i], mo, o);
            check(o == 1'b0, "R10", "oe in address phase", int'(o), 0);
        end
        for (int i = 0; i < data_bits; i++) begin
            bit_cyc(1'b0, mo, o);
            if (expect_out) begin
                if (i == 0) check(o == 1'b1, "R3", "oe on first data bit", int'(o), 1);
                acc = {acc[6:0], mo};
                if (i % 8 == 7) rx_q.push_back(acc);
            end else begin
                check(o == 1'b0, quiet_req, "oe while command rejected", int'(o), 0);
            end
        end
        tick(H);
        cs_n = 1'b1;
        tick(H);
        check(oe == 1'b0, "R6", "oe after deselect", int'(oe), 0);
        tick(H);
    endtask

    // monitor: compare each completed byte against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            while (rx_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] got;
                logic [7:0] want;
                string      tg;
                got  = rx_q.pop_front();
                want = exp_q.pop_front();
                tg   = tag_q.pop_front();
                check(got == want, tg, "data byte", int'(got), int'(want));
            end
        end
    end

    // watchdog
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(5);
        // R1: reset state
        check(oe == 1'b0, "R1", "oe during reset", int'(oe), 0);
        check(miso == 1'b0, "R1", "miso during reset", int'(miso), 0);
        rst = 1'b0;
        tick(1);
        check(oe == 1'b0, "R1", "oe after reset", int'(oe), 0);
        tick(5);

        // R2 R3 R4: plain read at 000005h
        push_exp(mem_val(24'h000005), "R2 R3");
        push_exp(mem_val(24'h000006), "R4");
        push_exp(mem_val(24'h000007), "R4");
        xfer(8'h03, 24'h000005, 24, 24, 1'b1, "");

        // R4: run past the end of the array index space
        for (int k = 0; k < 6; k++) push_exp(mem_val(24'h00003D + 24'(k)), "R4");
        xfer(8'h03, 24'h00003D, 24, 48, 1'b1, "");

        // R5: wrap from FFFFFFh to 000000h
        for (int k = 0; k < 5; k++) push_exp(mem_val(24'hFFFFFD + 24'(k)), "R5");
        xfer(8'h03, 24'hFFFFFD, 24, 40, 1'b1, "");

        // R8: identification sequence and filler
        for (int k = 0; k < 24; k++) push_exp(id_val(k), "R8");
        xfer(8'h9E, 24'h0, 0, 192, 1'b1, "");

        // R7: commands while busy
        busy = 1'b1;
        xfer(8'h03, 24'h000010, 24, 16, 1'b0, "R7");
        xfer(8'h9E, 24'h0, 0, 16, 1'b0, "R7");
        busy = 1'b0;
        push_exp(mem_val(24'h000010), "R7");
        xfer(8'h03, 24'h000010, 24, 8, 1'b1, "");

        // R9: unknown instructions
        xfer(8'h5A, 24'h0, 0, 16, 1'b0, "R9");
        xfer(8'h0B, 24'h0, 0, 16, 1'b0, "R9");

        // R6: abort mid byte, then a fresh read
        push_exp(mem_val(24'h00000A), "R6");
        push_exp(mem_val(24'h00000B), "R6");
        xfer(8'h03, 24'h00000A, 24, 19, 1'b1, "");
        push_exp(mem_val(24'h000014), "R6");
        push_exp(mem_val(24'h000015), "R6");
        xfer(8'h03, 24'h000014, 24, 16, 1'b1, "");

        // R6: abort inside the address phase, then a fresh read
        xfer(8'h03, 24'hABCDEF, 10, 0, 1'b0, "R6");
        push_exp(mem_val(24'h00002A), "R6");
        xfer(8'h03, 24'h00002A, 24, 8, 1'b1, "");

        // R6: abort in identification stream mid byte, restart from start
        push_exp(id_val(0), "R8");
        xfer(8'h9E, 24'h0, 0, 13, 1'b1, "");
        push_exp(id_val(0), "R8");
        push_exp(id_val(1), "R8");
        xfer(8'h9E, 24'h0, 0, 16, 1'b1, "");

        tick(20);
        check(exp_q.size() == 0, "R2", "bytes still expected", exp_q.size(), 0);
        check(rx_q.size() == 0, "R2", "bytes left uncompared", rx_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule